// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel that works through a ring of descriptors kept in system memory. Software builds each 32-byte descriptor (command, byte count, source address and mode, destination address and mode, a status slot and a link to the following descriptor). It then loads the channel's descriptor pointer, sets the enable bit and writes the doorbell. The channel reads the descriptor over a word-wide memory port and copies the programmed number of bytes from source to destination through that same port. It then writes a status word back into the descriptor, clears the descriptor's valid flag and follows the link.

Work stops in two ways. A fetched descriptor whose valid flag is clear stops the channel with no transfer. Clearing the enable bit stops it at the next element boundary. Both leave the halt bit set in the status register. A doorbell written while the channel is enabled restarts a stopped channel at its current pointer, so software can append descriptors after the engine has run dry. A per-descriptor interrupt-enable flag raises the channel interrupt once that descriptor is written back.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the status register (0x14) reads 1: halt bit 0 set, doorbell-pending bit 1 clear, current-valid bit 2 clear. The config register (0x00) reads 0, `irq` is low and no memory request is issued.
- R2: A write of any value to the doorbell register (0x0C) while config bit 0 (enable) is set makes a halted channel fetch the descriptor at its pointer. A doorbell write while enable is clear is ignored: the pending bit stays clear and no memory access occurs.
- R3: Descriptor word 0 carries the valid flag in bit 31. If that flag is clear, the channel halts after reading word 0 alone. It makes no transfer and no memory write. The halt bit drops one cycle after the doorbell write and is set again three cycles after it.
- R4: Word 0 bits 25:24 select the element width (0 byte, 1 halfword, 2 or 3 word). Each element costs one read and one write. The element comes from the source's lane, goes to the destination's lane, and is written under matching byte enables. The remaining count falls by the element size and floors at zero, so a count of N takes ceil(N/size) elements.
- R5: Bits 1:0 of word 3 (source) and word 5 (destination) select the address mode. Mode 1 holds the address fixed. Modes 0 (increment) and 2 (burst) advance it by the element size after each element.
- R6: On completion the channel writes word 6 with bit 31 set and the bytes moved in bits 30:0. It then rewrites word 0 with bit 31 cleared and every other bit unchanged.
- R7: After write-back the pointer takes word 7 with bits 4:0 forced to zero, and fetching continues while enabled. A ring of linked descriptors is walked in link order.
- R8: If word 0 bit 30 is set, the interrupt flag (`irq`, register 0x10 bit 0) sets when that descriptor's write-back ends. Any write to 0x10 clears it.
- R9: A byte count (word 1) of zero moves no data but still performs the write-back and the interrupt check.
- R10: Clearing enable lets the element in flight finish, then halts. There is no write-back. The current-valid bit stays set and the count register (0x18) shows the bytes not yet moved.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit. The pending bit is set by a doorbell written while the channel is busy.
- R12: Register map: 0x00 config, 0x04 descriptor pointer (writable only while halted, bits 4:0 read as zero), 0x08 status-slot address (pointer + 0x18), 0x0C doorbell, 0x10 interrupt, 0x14 status, 0x18 remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| irq | output | 1 | Channel interrupt flag |

## Verification
Every result has a fixed latency counted from the edge that takes the register write. The pending bit is set on that edge and the first fetch request goes out on the next one. Each descriptor word then takes two cycles, each element three, and the write-back two, and the interrupt flag sets on the edge that ends the write-back. The bench samples on falling edges. It tracks the halt bit cycle by cycle after a doorbell on an invalid descriptor. For longer runs it polls the halt bit and only then compares memory, status words, count and flags. The remaining count after a forced halt is checked against the number of destination writes seen at the memory model.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int DW         = 32;
  localparam int BE_W       = DW / 8;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_B    = $clog2(DESC_WORDS * BE_W);

  // descriptor word order (decoded by the sequencer)
  localparam int W_CMD0 = 0;
  localparam int W_CMD1 = 1;
  localparam int W_SRC0 = 2;
  localparam int W_SRC1 = 3;
  localparam int W_DST0 = 4;
  localparam int W_DST1 = 5;
  localparam int W_STAT = 6;
  localparam int W_NEXT = 7;

  // command word fields
  localparam int B_VALID = 31;
  localparam int B_IE    = 30;
  localparam int B_WIDTH = 24;

  // register offsets
  localparam int OFF_CFG  = 'h00;
  localparam int OFF_PTR  = 'h04;
  localparam int OFF_SPTR = 'h08;
  localparam int OFF_DB   = 'h0C;
  localparam int OFF_IRQ  = 'h10;
  localparam int OFF_STAT = 'h14;
  localparam int OFF_CNT  = 'h18;

  typedef enum logic [1:0] {AM_INC = 2'd0, AM_STATIC = 2'd1, AM_BURST = 2'd2, AM_RSVD = 2'd3} addr_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_RREQ, ST_RWAIT, ST_WREQ, ST_WBS, ST_WBC
  } seq_state_e;
endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            halted,
  input  logic [AW-1:0]   cur_ptr,
  input  logic [DW-1:0]   remain,
  input  logic            evt_valid,
  input  logic            evt_done,
  input  logic            evt_irq,
  input  logic            db_take,
  output logic            en,
  output logic            db_pending,
  output logic            ptr_wr,
  output logic [AW-1:0]   ptr_wdata,
  output logic            irq
);
  logic wr_cfg, wr_ptr, wr_db, wr_irq, wr_stat;
  logic en_q, en_n, db_q, db_n, cv_q, cv_n, irq_q, irq_n;
  logic en_ce, db_ce, cv_ce, irq_ce;

  assign wr_cfg  = reg_wr && (reg_addr == RA_W'(OFF_CFG));
  assign wr_ptr  = reg_wr && (reg_addr == RA_W'(OFF_PTR));
  assign wr_db   = reg_wr && (reg_addr == RA_W'(OFF_DB));
  assign wr_irq  = reg_wr && (reg_addr == RA_W'(OFF_IRQ));
  assign wr_stat = reg_wr && (reg_addr == RA_W'(OFF_STAT));

  always_comb begin
    en_n = reg_wdata[0];
    en_ce = wr_cfg;
    db_n = db_q;
    if (db_take) db_n = 1'b0;
    if (wr_stat && reg_wdata[1]) db_n = 1'b0;
    if (wr_db && en_q) db_n = 1'b1;
    db_ce = (db_n != db_q);
    cv_n = cv_q;
    if (evt_done) cv_n = 1'b0;
    if (wr_stat && reg_wdata[2]) cv_n = 1'b0;
    if (evt_valid) cv_n = 1'b1;
    cv_ce = (cv_n != cv_q);
    irq_n = irq_q;
    if (wr_irq) irq_n = 1'b0;
    if (evt_irq) irq_n = 1'b1;
    irq_ce = (irq_n != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      db_q  <= 1'b0;
      cv_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_ce)  en_q  <= en_n;
      if (db_ce)  db_q  <= db_n;
      if (cv_ce)  cv_q  <= cv_n;
      if (irq_ce) irq_q <= irq_n;
    end
  end

  assign en         = en_q;
  assign db_pending = db_q;
  assign irq        = irq_q;
  assign ptr_wr     = wr_ptr && halted;
  assign ptr_wdata  = reg_wdata[AW-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_W'(OFF_CFG):  reg_rdata = {{(DW-1){1'b0}}, en_q};
      RA_W'(OFF_PTR):  reg_rdata = DW'(cur_ptr);
      RA_W'(OFF_SPTR): reg_rdata = DW'(cur_ptr + AW'(W_STAT * BE_W));
      RA_W'(OFF_IRQ):  reg_rdata = {{(DW-1){1'b0}}, irq_q};
      RA_W'(OFF_STAT): reg_rdata = {{(DW-3){1'b0}}, cv_q, db_q, halted};
      RA_W'(OFF_CNT):  reg_rdata = remain;
      default:         reg_rdata = '0;
    endcase
  end

  // R8: a clear write with no completion in the same cycle leaves the flag low
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq && !evt_irq) |=> !irq_q);
  // R2: a doorbell while disabled never raises the pending bit
  a_r2_db_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_db && !en_q && !db_q) |=> !db_q);
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            db_pending,
  input  logic            ptr_wr,
  input  logic [AW-1:0]   ptr_wdata,
  output logic            db_take,
  output logic            evt_valid,
  output logic            evt_done,
  output logic            evt_irq,
  output logic            halted,
  output logic [AW-1:0]   cur_ptr,
  output logic [DW-1:0]   remain,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [BE_W-1:0] mem_be,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rvalid
);
  seq_state_e state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [AW-1:0]    ptr_q, ptr_n, src_q, src_n, dst_q, dst_n;
  logic [DW-1:0]    cnt_q, cnt_n, data_q, data_n;
  logic [DW-1:0]    desc_q [DESC_WORDS];
  logic [DW-1:0]    desc_n [DESC_WORDS];

  // element geometry
  logic [1:0]      width, slane, dlane;
  logic [3:0]      unit_b;
  logic [DW-1:0]   elem_mask, elem, cnt_left, moved;
  logic [BE_W-1:0] be_base;
  addr_mode_e      src_mode, dst_mode;
  logic [AW-1:0]   src_step, dst_step;

  assign width    = desc_q[W_CMD0][B_WIDTH +: 2];
  assign src_mode = addr_mode_e'(desc_q[W_SRC1][1:0]);
  assign dst_mode = addr_mode_e'(desc_q[W_DST1][1:0]);

  always_comb begin
    case (width)
      2'd0: begin unit_b = 4'd1; slane = src_q[1:0]; dlane = dst_q[1:0];
                  elem_mask = DW'(8'hFF); be_base = BE_W'(1); end
      2'd1: begin unit_b = 4'd2; slane = {src_q[1], 1'b0}; dlane = {dst_q[1], 1'b0};
                  elem_mask = DW'(16'hFFFF); be_base = BE_W'(3); end
      default: begin unit_b = 4'd4; slane = 2'd0; dlane = 2'd0;
                  elem_mask = '1; be_base = '1; end
    endcase
    elem     = (data_q >> {slane, 3'b000}) & elem_mask;
    cnt_left = (cnt_q <= DW'(unit_b)) ? '0 : cnt_q - DW'(unit_b);
    src_step = (src_mode == AM_STATIC) ? '0 : AW'(unit_b);
    dst_step = (dst_mode == AM_STATIC) ? '0 : AW'(unit_b);
    moved    = desc_q[W_CMD1] - cnt_q;
  end

  always_comb begin
    state_n = state_q; idx_n = idx_q; ptr_n = ptr_q; desc_n = desc_q;
    src_n = src_q; dst_n = dst_q; cnt_n = cnt_q; data_n = data_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_be = '0;
    db_take = 1'b0; evt_valid = 1'b0; evt_done = 1'b0; evt_irq = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ptr_wr) ptr_n = {ptr_wdata[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
        if (en && db_pending) begin
          db_take = 1'b1; idx_n = '0; state_n = ST_FREQ;
        end
      end
      ST_FREQ: begin
        if (!en) state_n = ST_IDLE;
        else begin
          mem_req = 1'b1; mem_addr = ptr_q + AW'({idx_q, 2'b00}); state_n = ST_FWAIT;
        end
      end
      ST_FWAIT: if (mem_rvalid) begin
        desc_n[idx_q] = mem_rdata;
        if (idx_q == IDX_W'(W_CMD0) && !mem_rdata[B_VALID]) state_n = ST_IDLE;
        else if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
          evt_valid = 1'b1;
          src_n = desc_q[W_SRC0][AW-1:0];
          dst_n = desc_q[W_DST0][AW-1:0];
          cnt_n = desc_q[W_CMD1];
          state_n = (desc_q[W_CMD1] == '0) ? ST_WBS : ST_RREQ;
        end else begin
          idx_n = idx_q + 1'b1; state_n = ST_FREQ;
        end
      end
      ST_RREQ: begin
        if (!en) state_n = ST_IDLE;
        else begin
          mem_req = 1'b1; mem_addr = {src_q[AW-1:2], 2'b00}; state_n = ST_RWAIT;
        end
      end
      ST_RWAIT: if (mem_rvalid) begin
        data_n = mem_rdata; state_n = ST_WREQ;
      end
      ST_WREQ: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = {dst_q[AW-1:2], 2'b00};
        mem_wdata = elem << {dlane, 3'b000}; mem_be = be_base << dlane;
        cnt_n = cnt_left; src_n = src_q + src_step; dst_n = dst_q + dst_step;
        if (cnt_left == '0) state_n = ST_WBS;
        else if (!en)       state_n = ST_IDLE;
        else                state_n = ST_RREQ;
      end
      ST_WBS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_be = '1;
        mem_addr = ptr_q + AW'(W_STAT * BE_W);
        mem_wdata = {1'b1, moved[DW-2:0]}; state_n = ST_WBC;
      end
      ST_WBC: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_be = '1; mem_addr = ptr_q;
        mem_wdata = desc_q[W_CMD0] & ~(DW'(1) << B_VALID);
        evt_done = 1'b1; evt_irq = desc_q[W_CMD0][B_IE];
        ptr_n = {desc_q[W_NEXT][AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
        idx_n = '0;
        state_n = en ? ST_FREQ : ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; idx_q <= '0; ptr_q <= '0; src_q <= '0;
      dst_q <= '0; cnt_q <= '0; data_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      if (ptr_n != ptr_q) ptr_q <= ptr_n;
      if (state_q == ST_FWAIT && mem_rvalid) desc_q <= desc_n;
      src_q <= src_n; dst_q <= dst_n; cnt_q <= cnt_n;
      if (state_q == ST_RWAIT && mem_rvalid) data_q <= data_n;
    end
  end

  assign halted  = (state_q == ST_IDLE);
  assign cur_ptr = ptr_q;
  assign remain  = cnt_q;

  // R12: a halted channel keeps the memory port quiet
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);
  // R4: every write carries at least one byte enable
  a_r4_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));
  // R4: a read is never followed by another request in the next cycle
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);
  // R10: without enable and a pending doorbell the channel stays halted
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !(en && db_pending)) |=> halted);
  // R5: a static source address never moves across an element
  a_r5_static_src: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WREQ && src_mode == AM_STATIC) |=> (src_q == $past(src_q)));
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [BE_W-1:0] mem_be,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rvalid,
  output logic            irq
);
  // reset asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic en, db_pending, ptr_wr, db_take, evt_valid, evt_done, evt_irq, halted;
  logic [AW-1:0] ptr_wdata, cur_ptr;
  logic [DW-1:0] remain;

  ring_dma_regs #(.AW(AW), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted),
    .cur_ptr(cur_ptr), .remain(remain), .evt_valid(evt_valid),
    .evt_done(evt_done), .evt_irq(evt_irq), .db_take(db_take), .en(en),
    .db_pending(db_pending), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .irq(irq)
  );

  ring_dma_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .en(en), .db_pending(db_pending),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .db_take(db_take),
    .evt_valid(evt_valid), .evt_done(evt_done), .evt_irq(evt_irq),
    .halted(halted), .cur_ptr(cur_ptr), .remain(remain), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );
endmodule

// File: tb/ring_dma_chan_bench.sv
`timescale 1ns/1ps
module ring_dma_chan_bench;
  localparam logic [4:0] A_CFG = 5'h00, A_PTR = 5'h04, A_SPTR = 5'h08, A_DB = 5'h0C,
                         A_IRQ = 5'h10, A_STAT = 5'h14, A_CNT = 5'h18;
  // vector: [7:0] count [9:8] src mode [11:10] dst mode [13:12] width [14] ie
  //         [19:16] src offset [23:20] dst offset
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_6010,  // word, 16 bytes, increment both, ie
    32'h0031_0007,  // byte, 7 bytes, odd lanes
    32'h0002_5106,  // half, static source
    32'h0040_240C,  // word, static destination
    32'h0020_5A0A,  // half, burst both
    32'h0000_6000   // zero count (R9)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_rvalid = 1'b0;
  logic tb_we = 1'b0;
  logic [7:0] tb_idx = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] bmem [256];
  logic [31:0] exp_mem [256];
  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;

  always #2.5 clk = ~clk;

  ring_dma_chan u_ring_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .irq(irq)
  );

  // memory model: read data one cycle after the request
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_we) bmem[tb_idx] <= tb_data;
    if (mem_req) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        rd_cnt <= rd_cnt + 1;
        mem_rdata  <= bmem[mem_addr[9:2]];
        mem_rvalid <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input int widx, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_idx = 8'(widx); tb_data = d;
    @(negedge clk); tb_we = 1'b0;
    exp_mem[widx] = d;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic wait_halt();
    logic [31:0] s;
    @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      reg_read(A_STAT, s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    return bmem[(a >> 2) & 255][8*(a & 3) +: 8];
  endfunction

  task automatic clear_dst();
    for (int w = 'h80; w < 'hC0; w++) if (bmem[w] != 0) poke(w, 32'h0);
  endtask

  task automatic cmp_dst(input string tag);
    int bad = 0; int first = -1;
    for (int w = 'h80; w < 'hC0; w++)
      if (bmem[w] !== exp_mem[w]) begin bad++; if (first < 0) first = w; end
    if (first < 0) chk(tag, 32'h0, 32'h0);
    else chk(tag, bmem[first], exp_mem[first]);
  endtask

  task automatic run_vec(input logic [31:0] v, input int n);
    int cnt = int'(v[7:0]);
    int sm = int'(v[9:8]), dm = int'(v[11:10]), wd = int'(v[13:12]);
    int u = (wd == 0) ? 1 : (wd == 1) ? 2 : 4;
    int sa = 'h100 + int'(v[19:16]), da = 'h200 + int'(v[23:20]);
    logic [31:0] cmd0 = 32'h8000_00A5 | (32'(v[14]) << 30) | (32'(wd) << 24);
    logic [31:0] r;
    clear_dst();
    poke(0, cmd0); poke(1, 32'(cnt)); poke(2, 32'(sa)); poke(3, 32'(sm));
    poke(4, 32'(da)); poke(5, 32'(dm)); poke(6, 32'h0); poke(7, 32'h0);
    for (int k = 0; k < (cnt + u - 1) / u; k++) begin
      int s0 = sa & ~(u - 1); int d0 = da & ~(u - 1);
      for (int b = 0; b < u; b++)
        exp_mem[((d0 + b) >> 2) & 255][8*((d0 + b) & 3) +: 8] = mbyte(s0 + b);
      if (sm != 1) sa += u;
      if (dm != 1) da += u;
    end
    reg_write(A_PTR, 32'h0); reg_write(A_CFG, 32'h1); reg_write(A_DB, 32'h0);
    wait_halt();
    cmp_dst($sformatf("R4/R5/R9 vec%0d data", n));
    chk($sformatf("R6 vec%0d status word", n), bmem[6], 32'h8000_0000 | 32'(cnt));
    chk($sformatf("R6 vec%0d valid cleared", n), bmem[0], cmd0 & 32'h7FFF_FFFF);
    chk($sformatf("R8 vec%0d irq", n), 32'(irq), 32'(v[14]));
    reg_read(A_CNT, r);  chk($sformatf("R12 vec%0d count", n), r, 32'h0);
    reg_read(A_PTR, r);  chk($sformatf("R7 vec%0d pointer", n), r, 32'h0);
    reg_write(A_IRQ, 32'h0);
    chk($sformatf("R8 vec%0d irq cleared", n), 32'(irq), 32'h0);
    reg_write(A_CFG, 32'h0);
  endtask

  initial begin
    logic [31:0] r, h1, h3;
    int rd0, wr0;
    for (int i = 0; i < 256; i++) begin bmem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(A_STAT, r); chk("R1 status", r, 32'h1);
    reg_read(A_CFG, r);  chk("R1 config", r, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 no request", 32'(mem_req), 32'h0);
    for (int i = 'h40; i < 'h80; i++)
      poke(i, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h5A5A_5A5A);

    for (int n = 0; n < NV; n++) run_vec(VEC[n], n);

    // R2: doorbell with enable clear is ignored
    clear_dst();
    poke(0, 32'h8200_0000); poke(1, 32'h8); poke(2, 32'h100); poke(3, 0);
    poke(4, 32'h200); poke(5, 0); poke(6, 0); poke(7, 0);
    rd0 = rd_cnt;
    reg_write(A_DB, 32'h0);
    repeat (10) @(negedge clk);
    reg_read(A_STAT, r); chk("R2 disabled doorbell status", r, 32'h1);
    chk("R2 disabled doorbell no access", 32'(rd_cnt - rd0), 32'h0);

    // R3: invalid descriptor halts after one read, exact halt timing
    poke(0, 32'h0200_0000); poke(6, 32'hDEAD_0006);
    reg_write(A_CFG, 32'h1);
    rd0 = rd_cnt; wr0 = wr_cnt;
    reg_write(A_DB, 32'h0);
    @(negedge clk); reg_read(A_STAT, h1);
    @(negedge clk);
    @(negedge clk); reg_read(A_STAT, h3);
    chk("R3 halt drops after doorbell", 32'(h1[0]), 32'h0);
    chk("R3 halt returns three cycles later", 32'(h3[0]), 32'h1);
    chk("R3 single read", 32'(rd_cnt - rd0), 32'h1);
    chk("R3 no writes", 32'(wr_cnt - wr0), 32'h0);
    chk("R3 status untouched", bmem[6], 32'hDEAD_0006);
    chk("R3 no transfer", bmem['h80], 32'h0);
    reg_write(A_CFG, 32'h0);

    // R7: two-descriptor ring, then append and ring the doorbell again
    poke('hC0, 32'h8200_0000); poke('hC1, 8); poke('hC2, 32'h100); poke('hC3, 0);
    poke('hC4, 32'h200); poke('hC5, 0); poke('hC6, 0); poke('hC7, 32'h0000_033F);
    poke('hC8, 32'hC200_0000); poke('hC9, 8); poke('hCA, 32'h140); poke('hCB, 0);
    poke('hCC, 32'h240); poke('hCD, 0); poke('hCE, 0); poke('hCF, 32'h300);
    reg_write(A_PTR, 32'h300); reg_write(A_CFG, 32'h1); reg_write(A_DB, 32'h0);
    wait_halt();
    chk("R7 first copy", bmem['h81], bmem['h41]);
    chk("R7 second copy", bmem['h91], bmem['h51]);
    chk("R7 first status", bmem['hC6], 32'h8000_0008);
    chk("R7 second status", bmem['hCE], 32'h8000_0008);
    reg_read(A_PTR, r); chk("R7 pointer wrapped", r, 32'h300);
    reg_read(A_SPTR, r); chk("R12 status slot address", r, 32'h318);
    chk("R8 irq from second only", 32'(irq), 32'h1);
    reg_write(A_IRQ, 32'h0);
    poke('hC4, 32'h260); poke('hC0, 32'h8200_0000);
    reg_write(A_DB, 32'h0);
    wait_halt();
    chk("R2 restart after append", bmem['h98], bmem['h40]);
    reg_read(A_PTR, r); chk("R2 pointer after append", r, 32'h320);
    reg_write(A_CFG, 32'h0);

    // R10/R11: disable mid-transfer, pending and valid bits cleared by writes
    clear_dst();
    poke(0, 32'hC200_0000); poke(1, 32'd256); poke(2, 32'h100); poke(3, 0);
    poke(4, 32'h200); poke(5, 0); poke(6, 0); poke(7, 0);
    reg_write(A_PTR, 32'h0); reg_write(A_CFG, 32'h1);
    wr0 = wr_cnt;
    reg_write(A_DB, 32'h0);
    repeat (40) @(negedge clk);
    reg_write(A_DB, 32'h0);
    reg_read(A_STAT, r); chk("R11 pending set while busy", 32'(r[1]), 32'h1);
    reg_write(A_STAT, 32'h2);
    reg_read(A_STAT, r); chk("R11 pending cleared", 32'(r[1]), 32'h0);
    reg_write(A_CFG, 32'h0);
    wait_halt();
    reg_read(A_STAT, r); chk("R10 halted with valid held", r, 32'h5);
    reg_read(A_CNT, r);
    chk("R10 remaining count", r, 32'(256 - 4 * (wr_cnt - wr0)));
    chk("R10 partial run", 32'((wr_cnt - wr0) > 0 && (wr_cnt - wr0) < 64), 32'h1);
    chk("R10 no write-back", bmem[6], 32'h0);
    chk("R10 no irq", 32'(irq), 32'h0);
    reg_write(A_STAT, 32'h4);
    reg_read(A_STAT, r); chk("R11 valid cleared", r, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule